// File: doc/BRIEF.md
# Registered/Latched Bidirectional Bus Transceiver

A two-way bus transceiver built from independent sections, each `SECT_W` bits wide (two sections of 18 bits by default). Each section carries data from port A to port B and from port B to port A. Each direction has its own storage stage and its own output enable. The storage stage works in one of three ways:

- **Transparent:** the input passes straight to the output while the latch enable is high.
- **Held:** the stored value stays put while the latch enable is low and the direction clock is steady.
- **Captured:** new data is loaded on each rising transition of the direction clock while the latch enable is low.

The direction clock is not a true clock. It is a control input sampled by the system clock, and a rising transition is detected as low on one sample and high on the next.

Each input bit has a keeper. A per-bit drive flag tells the block whether the bit is being driven. When the flag drops, the keeper supplies the last driven value, so the storage stage never sees an undefined input. Real tristate pads are not modelled. Each output port instead reports a per-bit enable vector, and the output data reads zero wherever the enable is inactive.

The two directions use opposite enable polarity: A-to-B is active high and B-to-A is active low.

Top module: `bidir_xcvr`

## Requirements
- R1: While a direction's latch enable is high, its output equals the effective input in the same cycle, with no clock delay. The effective input is the input bit when its drive flag is 1, and the keeper value otherwise.
- R2: While the latch enable is low and the direction clock sample shows no low-to-high change, the output holds its stored value whatever the input does.
- R3: While the latch enable is low, a direction clock sampled high on a system edge after being sampled low on the previous edge loads the effective input present at that edge. From the next cycle on, the output shows that value.
- R4: When the latch enable falls while the direction clock is high, the output keeps the value last passed through. It changes only after the next low-to-high clock transition.
- R5: `b_oe_o` repeats `oe_ab_i[s]` (active high) across the bits of section s. `b_o` is 0 on every bit whose enable is 0.
- R6: `a_oe_o` repeats the inverse of `oe_ba_ni[s]` (active low) across the bits of section s. `a_o` is 0 on every bit whose enable is 0. Otherwise B-to-A flow behaves as R1 to R4 do, using `le_ba_i` and `clk_ba_i`.
- R7: A keeper bit loads its input bit only in cycles where that bit's drive flag is 1. Otherwise it keeps its value and stands in for the input.
- R8: The controls with index s affect only bits `[s*SECT_W +: SECT_W]`.
- R9: The active-low asynchronous reset clears all storage, all keepers and the clock samples to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| a_i | input | 36 | port A input data |
| a_drv_i | input | 36 | port A per-bit drive flag |
| b_i | input | 36 | port B input data |
| b_drv_i | input | 36 | port B per-bit drive flag |
| oe_ab_i | input | 2 | per-section B output enable, active high |
| oe_ba_ni | input | 2 | per-section A output enable, active low |
| le_ab_i | input | 2 | per-section A-to-B latch enable |
| le_ba_i | input | 2 | per-section B-to-A latch enable |
| clk_ab_i | input | 2 | per-section A-to-B capture clock (sampled) |
| clk_ba_i | input | 2 | per-section B-to-A capture clock (sampled) |
| b_o | output | 36 | port B output data |
| b_oe_o | output | 36 | port B per-bit output enable |
| a_o | output | 36 | port A output data |
| a_oe_o | output | 36 | port A per-bit output enable |

## Verification
The patterns are chosen so that each one tells two storage modes or two sections apart:

- **Transparent vs. clocked:** changing data with the latch enable high shows any stray register delay in the transparent path.
- **Hold vs. capture:** data changing with the clock steady, followed by single clock pulses, separates holding from capturing.
- **Spurious capture:** lowering the latch enable while the clock is already high catches a capture where none should occur.
- **Keeper updates:** a partial drive mask with new data on the undriven bits shows whether the keeper loads when it should not.
- **Polarity and section isolation:** toggling each enable, and giving the two sections different modes, exposes swapped polarity and controls that reach across sections.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  typedef struct packed {
    logic le;   // transparent when high
    logic clk;  // sampled capture clock
    logic oe;   // active-high internal enable
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_keeper.sv
`timescale 1ns/1ps
module xcvr_keeper #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] drv_i,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] keep_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) keep_q <= '0;
    else         keep_q <= (d_i & drv_i) | (keep_q & ~drv_i);

  assign eff_o = (d_i & drv_i) | (keep_q & ~drv_i);

  // R7
  keeper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((keep_q ^ $past(keep_q)) & ~$past(drv_i)) == '0));
endmodule

// File: rtl/xcvr_store.sv
`timescale 1ns/1ps
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  dir_ctrl_t    ctrl_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic         clk_q;
  logic         rise;
  logic [W-1:0] store_q;

  assign rise = ctrl_i.clk & ~clk_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      clk_q   <= 1'b0;
      store_q <= '0;
    end else begin
      clk_q <= ctrl_i.clk;
      if (ctrl_i.le || rise) store_q <= d_i;
    end

  // transparent bypass
  assign q_o = ctrl_i.le ? d_i : store_q;

  // R2
  store_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.le && !(ctrl_i.clk && !clk_q)) |=> $stable(store_q));

  // R3
  store_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.le && ctrl_i.clk && !clk_q) |=> (store_q == $past(d_i)));
endmodule

// File: rtl/xcvr_dir.sv
`timescale 1ns/1ps
module xcvr_dir
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  dir_ctrl_t    ctrl_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] drv_i,
  output logic [W-1:0] y_o,
  output logic [W-1:0] oe_o
);
  logic [W-1:0] eff;
  logic [W-1:0] val;

  xcvr_keeper #(.W(W)) u_keep (
    .clk_i, .rst_ni, .d_i, .drv_i, .eff_o(eff)
  );

  xcvr_store #(.W(W)) u_store (
    .clk_i, .rst_ni, .ctrl_i, .d_i(eff), .q_o(val)
  );

  assign oe_o = {W{ctrl_i.oe}};
  assign y_o  = ctrl_i.oe ? val : '0;
endmodule

// File: rtl/bidir_xcvr.sv
`timescale 1ns/1ps
module bidir_xcvr
  import xcvr_pkg::*;
#(
  parameter int SECT_W = 18,
  parameter int N_SECT = 2,
  localparam int TOT_W = SECT_W * N_SECT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TOT_W-1:0] a_i,
  input  logic [TOT_W-1:0] a_drv_i,
  input  logic [TOT_W-1:0] b_i,
  input  logic [TOT_W-1:0] b_drv_i,
  input  logic [N_SECT-1:0] oe_ab_i,
  input  logic [N_SECT-1:0] oe_ba_ni,
  input  logic [N_SECT-1:0] le_ab_i,
  input  logic [N_SECT-1:0] le_ba_i,
  input  logic [N_SECT-1:0] clk_ab_i,
  input  logic [N_SECT-1:0] clk_ba_i,
  output logic [TOT_W-1:0] b_o,
  output logic [TOT_W-1:0] b_oe_o,
  output logic [TOT_W-1:0] a_o,
  output logic [TOT_W-1:0] a_oe_o
);
  for (genvar s = 0; s < N_SECT; s++) begin : g_sect
    dir_ctrl_t ab_ctrl, ba_ctrl;
    assign ab_ctrl = '{le: le_ab_i[s], clk: clk_ab_i[s], oe: oe_ab_i[s]};
    assign ba_ctrl = '{le: le_ba_i[s], clk: clk_ba_i[s], oe: ~oe_ba_ni[s]};

    xcvr_dir #(.W(SECT_W)) u_ab (
      .clk_i, .rst_ni, .ctrl_i(ab_ctrl),
      .d_i  (a_i    [s*SECT_W +: SECT_W]),
      .drv_i(a_drv_i[s*SECT_W +: SECT_W]),
      .y_o  (b_o    [s*SECT_W +: SECT_W]),
      .oe_o (b_oe_o [s*SECT_W +: SECT_W])
    );

    xcvr_dir #(.W(SECT_W)) u_ba (
      .clk_i, .rst_ni, .ctrl_i(ba_ctrl),
      .d_i  (b_i    [s*SECT_W +: SECT_W]),
      .drv_i(b_drv_i[s*SECT_W +: SECT_W]),
      .y_o  (a_o    [s*SECT_W +: SECT_W]),
      .oe_o (a_oe_o [s*SECT_W +: SECT_W])
    );
  end

  // R5
  b_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_o & ~b_oe_o) == '0);

  // R6
  a_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_o & ~a_oe_o) == '0);
endmodule

// File: tb/bidir_xcvr_test.sv
`timescale 1ns/1ps
module bidir_xcvr_test;
  localparam int SW = 18;
  localparam int NS = 2;
  localparam int TW = SW * NS;

  logic clk = 0, rst_ni = 0;
  logic [TW-1:0] a_i = '0, a_drv = '0, b_i = '0, b_drv = '0;
  logic [NS-1:0] oe_ab = '0, oe_ba_n = '1, le_ab = '0, le_ba = '0, ck_ab = '0, ck_ba = '0;
  logic [TW-1:0] b_o, b_oe, a_o, a_oe;

  always #5 clk = ~clk;

  bidir_xcvr uut (
    .clk_i(clk), .rst_ni, .a_i, .a_drv_i(a_drv), .b_i, .b_drv_i(b_drv),
    .oe_ab_i(oe_ab), .oe_ba_ni(oe_ba_n), .le_ab_i(le_ab), .le_ba_i(le_ba),
    .clk_ab_i(ck_ab), .clk_ba_i(ck_ba),
    .b_o, .b_oe_o(b_oe), .a_o, .a_oe_o(a_oe)
  );

  // behavioural reference state
  logic [TW-1:0] m_ka = '0, m_kb = '0, m_sab = '0, m_sba = '0;
  logic [NS-1:0] m_cab = '0, m_cba = '0;
  int n_chk = 0, n_fail = 0;
  string tag = "R9";

  task automatic cmp(string what, logic [TW-1:0] act, logic [TW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic [TW-1:0] eb, eboe, ea, eaoe;
    for (int i = 0; i < TW; i++) begin
      int s = i / SW;
      logic fa = a_drv[i] ? a_i[i] : m_ka[i];
      logic fb = b_drv[i] ? b_i[i] : m_kb[i];
      logic vb = le_ab[s] ? fa : m_sab[i];
      logic va = le_ba[s] ? fb : m_sba[i];
      eboe[i] = oe_ab[s];
      eaoe[i] = !oe_ba_n[s];
      eb[i]   = eboe[i] ? vb : 1'b0;
      ea[i]   = eaoe[i] ? va : 1'b0;
    end
    cmp("b_o", b_o, eb);
    cmp("b_oe_o", b_oe, eboe);
    cmp("a_o", a_o, ea);
    cmp("a_oe_o", a_oe, eaoe);
  endtask

  task automatic update();
    for (int i = 0; i < TW; i++) begin
      int s = i / SW;
      logic fa = a_drv[i] ? a_i[i] : m_ka[i];
      logic fb = b_drv[i] ? b_i[i] : m_kb[i];
      if (le_ab[s] || (ck_ab[s] && !m_cab[s])) m_sab[i] = fa;
      if (le_ba[s] || (ck_ba[s] && !m_cba[s])) m_sba[i] = fb;
      if (a_drv[i]) m_ka[i] = a_i[i];
      if (b_drv[i]) m_kb[i] = b_i[i];
    end
    m_cab = ck_ab;
    m_cba = ck_ba;
  endtask

  task automatic step();
    #1 check_all();
    update();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [TW-1:0] rnd();
    return {$urandom(), $urandom()};
  endfunction

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R9: cleared state seen once enables are on
    oe_ab = '1; oe_ba_n = '0;
    step(); step();

    // R1: transparent both ways
    tag = "R1";
    le_ab = '1; le_ba = '1; a_drv = '1; b_drv = '1;
    for (int k = 0; k < 6; k++) begin a_i = rnd(); b_i = rnd(); step(); end

    // R4: latch enable drops while clock high
    tag = "R4";
    ck_ab = '1; ck_ba = '1; step();
    le_ab = '0; le_ba = '0;
    for (int k = 0; k < 3; k++) begin a_i = rnd(); b_i = rnd(); step(); end
    ck_ab = '0; ck_ba = '0; step();
    ck_ab = '1; ck_ba = '1; step();

    // R3: clocked capture
    tag = "R3";
    for (int k = 0; k < 8; k++) begin
      a_i = rnd(); b_i = rnd();
      ck_ab = ~ck_ab; ck_ba = ~ck_ba; step();
    end

    // R2: hold with steady clock
    tag = "R2";
    for (int k = 0; k < 5; k++) begin a_i = rnd(); b_i = rnd(); step(); end

    // R7: partial drive, keeper supplies undriven bits
    tag = "R7";
    le_ab = '1; le_ba = '1;
    for (int k = 0; k < 8; k++) begin
      a_drv = rnd(); b_drv = rnd(); a_i = rnd(); b_i = rnd(); step();
    end
    a_drv = '0; b_drv = '0;
    for (int k = 0; k < 3; k++) begin a_i = rnd(); b_i = rnd(); step(); end
    a_drv = '1; b_drv = '1;

    // R5: A-to-B enable active high
    tag = "R5";
    for (int k = 0; k < 4; k++) begin oe_ab = 2'(k); a_i = rnd(); step(); end
    oe_ab = '1;

    // R6: B-to-A enable active low, clocked mode
    tag = "R6";
    le_ba = '0;
    for (int k = 0; k < 6; k++) begin
      oe_ba_n = 2'(k); b_i = rnd(); ck_ba = ~ck_ba; step();
    end
    oe_ba_n = '0;

    // R8: sections in different modes
    tag = "R8";
    le_ab = 2'b01; le_ba = 2'b10; ck_ab = '0; ck_ba = '0;
    for (int k = 0; k < 10; k++) begin
      a_i = rnd(); b_i = rnd();
      ck_ab[1] = ~ck_ab[1]; ck_ba[0] = (k % 3 == 0);
      step();
    end

    // R9: asynchronous reset mid-run
    tag = "R9";
    le_ab = '0; le_ba = '0; ck_ab = '0; ck_ba = '0;
    #2 rst_ni = 0;
    m_ka = '0; m_kb = '0; m_sab = '0; m_sba = '0; m_cab = '0; m_cba = '0;
    @(negedge clk); rst_ni = 1;
    step(); step();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule